// File: doc/BRIEF.md
# Time-Base and Watchdog Interrupt Generator

This block turns a system clock enable into a slow periodic time base and a watchdog timeout. One free-running divider chain does both jobs. When the fast source is in use, the system tick first passes through a divide-by-8 prescaler to reach the 32 kHz rate. The 32 kHz tick then feeds a 15-bit counter. A 3-bit frequency code picks the counter bit that forms the time base, at 1, 2, 4, 8, 16, 32, 64 or 128 Hz. The watchdog is a 2-bit stage that advances once per time-base period. On its fourth advance it sets a sticky timeout flag.

A host-side command decoder drives the block with one-cycle strobes. The strobes switch the system on or off, start or stop the divider, choose whether the interrupt pin carries the time base or the watchdog flag, clear the divider or the watchdog, enable or release the interrupt pin, and load a new frequency code. The interrupt pin is active low and open drain. `irq_oe` is high when the pin is driven. While the pin is released, `irq_n` reads 1.

Top module: `timebase_wdt`

## Requirements
- R1: After reset the interrupt pin is released (`irq_oe`=0, `irq_n`=1), the system is off, the time base is the selected interrupt source, the divider is cleared and the frequency code is 7 (128 Hz).
- R2: While the system is off, neither the prescaler, the divider nor the watchdog advances on `sys_tick`.
- R3: With the crystal source (`src_256k`=0) and code 7, `irq_n` in time-base mode stays 1 for the first 128 ticks after the divider is cleared and goes to 0 on the 128th tick.
- R4: With `src_256k`=1, eight system ticks make one 32 kHz tick, so the code-7 half period becomes 1024 system ticks.
- R5: Frequency code k gives a time-base period of 2^(15-k) 32 kHz ticks (code 0 = 1 Hz, code 7 = 128 Hz). The code is taken from `freq_sel` on `cmd_freq_ld`.
- R6: In time-base mode with the pin enabled, `irq_n` is a square wave: 1 during the first half of each period and 0 during the second half.
- R7: After watchdog mode is entered with `cmd_wdt_en`, the timeout flag sets on the 4th period wrap. `irq_n` then stays 0 until `cmd_clr_wdt` or `cmd_irq_dis`.
- R8: `cmd_clr_wdt` clears the timeout flag, the watchdog stage, the divider and the prescaler.
- R9: `cmd_irq_dis` releases the pin (`irq_oe`=0, `irq_n`=1) and drops a pending timeout flag. `cmd_irq_en` drives the pin again.
- R10: `cmd_clr_timer` clears the divider and the prescaler but keeps the watchdog stage count.
- R11: `cmd_timer_dis` or `cmd_wdt_dis` freezes the divider. `cmd_timer_en` or `cmd_wdt_en` resumes it from the held count.
- R12: The chain advances only in cycles where `sys_tick` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sys_tick | input | 1 | System clock enable, one cycle per source period |
| src_256k | input | 1 | 1: fast source, prescaled by 8; 0: crystal source used directly |
| cmd_sys_en | input | 1 | Strobe: system on |
| cmd_sys_dis | input | 1 | Strobe: system off |
| cmd_timer_en | input | 1 | Strobe: run divider, time base drives the pin |
| cmd_timer_dis | input | 1 | Strobe: stop divider |
| cmd_wdt_en | input | 1 | Strobe: run divider, watchdog flag drives the pin |
| cmd_wdt_dis | input | 1 | Strobe: stop divider |
| cmd_clr_timer | input | 1 | Strobe: clear divider and prescaler |
| cmd_clr_wdt | input | 1 | Strobe: clear divider, prescaler and watchdog |
| cmd_irq_en | input | 1 | Strobe: drive interrupt pin |
| cmd_irq_dis | input | 1 | Strobe: release interrupt pin |
| cmd_freq_ld | input | 1 | Strobe: load `freq_sel` |
| freq_sel | input | 3 | Frequency code, 0 = 1 Hz up to 7 = 128 Hz |
| irq_n | output | 1 | Active-low interrupt level |
| irq_oe | output | 1 | 1 while the pin is driven |

## Verification
The bench targets the exact edge of each half period and each timeout. A wrongly chosen counter bit or a missing prescaler shows up as `irq_n` changing one half period too early or too late. It also checks that a divider clear leaves the watchdog stage intact. If a clear also reset that stage, the timeout would slip by three periods. The timeout latch is run far past the flag, and the bench confirms that releasing the pin drops the flag. A latch that self-cleared, or a flag that survived the release, would show a wrong `irq_n` at once. Long runs with the system off or the divider stopped catch any advance that leaks through the gating.

// File: rtl/tbw_pkg.sv
package tbw_pkg;
    localparam int FREQ_W = 3;

    typedef enum logic {
        PIN_TIMEBASE = 1'b0,
        PIN_WATCHDOG = 1'b1
    } pin_src_e;

    typedef struct packed {
        logic              sys_on;
        logic              run;
        pin_src_e          src;
        logic              irq_en;
        logic [FREQ_W-1:0] freq;
    } ctrl_t;
endpackage

// File: rtl/tbw_prescale.sv
module tbw_prescale #(
    parameter int PRE_W = 3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tick_in,
    input  logic active,
    input  logic use_pre,
    input  logic clr,
    output logic tick_out
);
    logic [PRE_W-1:0] pre_d, pre_q;

    always_comb begin
        pre_d = pre_q;
        if (clr)
            pre_d = '0;
        else if (tick_in && active && use_pre)
            pre_d = pre_q + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            pre_q <= '0;
        else
            pre_q <= pre_d;
    end

    assign tick_out = tick_in && active && (!use_pre || (pre_q == '1));
endmodule

// File: rtl/tbw_divider.sv
module tbw_divider #(
    parameter int TB_W  = 8,
    parameter int SEL_W = 3,
    localparam int MAXSEL = (1 << SEL_W) - 1,
    localparam int CNT_W  = TB_W + MAXSEL,
    localparam int IDX_W  = $clog2(CNT_W)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick32,
    input  logic             run,
    input  logic             clr,
    input  logic [SEL_W-1:0] sel,
    output logic             level,
    output logic             wrap,
    output logic [CNT_W-1:0] cnt
);
    logic [CNT_W-1:0] cnt_d, cnt_q;
    logic [IDX_W-1:0] top_bit;
    logic [CNT_W-1:0] mask;

    always_comb begin
        top_bit = IDX_W'(TB_W - 1 + MAXSEL) - IDX_W'(sel);
        for (int i = 0; i < CNT_W; i++)
            mask[i] = (IDX_W'(i) <= top_bit);
        level = cnt_q[top_bit];
        wrap  = tick32 && run && (&(cnt_q | ~mask));
        cnt_d = cnt_q;
        if (clr)
            cnt_d = '0;
        else if (tick32 && run)
            cnt_d = cnt_q + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            cnt_q <= '0;
        else
            cnt_q <= cnt_d;
    end

    assign cnt = cnt_q;
endmodule

// File: rtl/tbw_watchdog.sv
module tbw_watchdog #(
    parameter int WDT_W = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic advance,
    input  logic clr,
    input  logic drop,
    output logic flag
);
    typedef struct packed {
        logic [WDT_W-1:0] stage;
        logic             flag;
    } wdt_t;

    wdt_t wdt_d, wdt_q;

    always_comb begin
        wdt_d = wdt_q;
        if (clr) begin
            wdt_d = '0;
        end else begin
            if (drop)
                wdt_d.flag = 1'b0;
            if (advance) begin
                wdt_d.stage = wdt_q.stage + 1'b1;
                if (wdt_q.stage == '1)
                    wdt_d.flag = 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            wdt_q <= '0;
        else
            wdt_q <= wdt_d;
    end

    assign flag = wdt_q.flag;
endmodule

// File: rtl/timebase_wdt.sv
module timebase_wdt
    import tbw_pkg::*;
#(
    parameter int PRE_W = 3,
    parameter int TB_W  = 8,
    parameter int WDT_W = 2,
    localparam int CNT_W = TB_W + (1 << FREQ_W) - 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sys_tick,
    input  logic              src_256k,
    input  logic              cmd_sys_en,
    input  logic              cmd_sys_dis,
    input  logic              cmd_timer_en,
    input  logic              cmd_timer_dis,
    input  logic              cmd_wdt_en,
    input  logic              cmd_wdt_dis,
    input  logic              cmd_clr_timer,
    input  logic              cmd_clr_wdt,
    input  logic              cmd_irq_en,
    input  logic              cmd_irq_dis,
    input  logic              cmd_freq_ld,
    input  logic [FREQ_W-1:0] freq_sel,
    output logic              irq_n,
    output logic              irq_oe
);
    ctrl_t ctrl_d, ctrl_q;

    logic             clr_div;
    logic             tick32;
    logic             tb_level;
    logic             tb_wrap;
    logic [CNT_W-1:0] div_cnt;
    logic             wdt_flag;
    logic             wdt_mode;
    logic             sys_on;
    logic             div_run;

    assign clr_div  = cmd_clr_timer || cmd_clr_wdt;
    assign wdt_mode = (ctrl_q.src == PIN_WATCHDOG);
    assign sys_on   = ctrl_q.sys_on;
    assign div_run  = ctrl_q.run;

    always_comb begin
        ctrl_d = ctrl_q;
        if (cmd_sys_en)  ctrl_d.sys_on = 1'b1;
        if (cmd_sys_dis) ctrl_d.sys_on = 1'b0;
        if (cmd_timer_en) begin
            ctrl_d.run = 1'b1;
            ctrl_d.src = PIN_TIMEBASE;
        end
        if (cmd_wdt_en) begin
            ctrl_d.run = 1'b1;
            ctrl_d.src = PIN_WATCHDOG;
        end
        if (cmd_timer_dis || cmd_wdt_dis) ctrl_d.run = 1'b0;
        if (cmd_irq_en)  ctrl_d.irq_en = 1'b1;
        if (cmd_irq_dis) ctrl_d.irq_en = 1'b0;
        if (cmd_freq_ld) ctrl_d.freq = freq_sel;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctrl_q.sys_on <= 1'b0;
            ctrl_q.run    <= 1'b1;
            ctrl_q.src    <= PIN_TIMEBASE;
            ctrl_q.irq_en <= 1'b0;
            ctrl_q.freq   <= '1;
        end else begin
            ctrl_q <= ctrl_d;
        end
    end

    tbw_prescale #(.PRE_W(PRE_W)) u_pre (
        .clk      (clk),
        .rst_n    (rst_n),
        .tick_in  (sys_tick),
        .active   (ctrl_q.sys_on),
        .use_pre  (src_256k),
        .clr      (clr_div),
        .tick_out (tick32)
    );

    tbw_divider #(.TB_W(TB_W), .SEL_W(FREQ_W)) u_div (
        .clk    (clk),
        .rst_n  (rst_n),
        .tick32 (tick32),
        .run    (ctrl_q.run),
        .clr    (clr_div),
        .sel    (ctrl_q.freq),
        .level  (tb_level),
        .wrap   (tb_wrap),
        .cnt    (div_cnt)
    );

    tbw_watchdog #(.WDT_W(WDT_W)) u_wdt (
        .clk     (clk),
        .rst_n   (rst_n),
        .advance (tb_wrap && wdt_mode),
        .clr     (cmd_clr_wdt),
        .drop    (cmd_irq_dis),
        .flag    (wdt_flag)
    );

    always_comb begin
        irq_oe = ctrl_q.irq_en;
        if (!ctrl_q.irq_en)
            irq_n = 1'b1;
        else if (wdt_mode)
            irq_n = !wdt_flag;
        else
            irq_n = !tb_level;
    end
endmodule

// File: rtl/tbw_checker.sv
module tbw_checker #(
    parameter int CNT_W = 15
) (
    input logic             clk,
    input logic             rst_n,
    input logic             cmd_irq_dis,
    input logic             cmd_clr_timer,
    input logic             cmd_clr_wdt,
    input logic             cmd_timer_en,
    input logic             irq_n,
    input logic             irq_oe,
    input logic             wdt_mode,
    input logic             sys_on,
    input logic             div_run,
    input logic [CNT_W-1:0] div_cnt,
    input logic             wdt_flag
);
    // R9
    irq_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_irq_dis |=> (!irq_oe && irq_n));

    // R7
    timeout_latch_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_oe && wdt_mode && !irq_n && !cmd_clr_wdt && !cmd_irq_dis && !cmd_timer_en)
        |=> !irq_n);

    // R2
    sys_off_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!sys_on && !cmd_clr_timer && !cmd_clr_wdt) |=> $stable(div_cnt));

    // R11
    div_stop_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!div_run && !cmd_clr_timer && !cmd_clr_wdt) |=> $stable(div_cnt));

    // R10
    clr_timer_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_clr_timer |=> (div_cnt == '0));

    // R8
    clr_wdt_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_clr_wdt |=> (!wdt_flag && div_cnt == '0));
endmodule

bind timebase_wdt tbw_checker #(.CNT_W(CNT_W)) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .cmd_irq_dis   (cmd_irq_dis),
    .cmd_clr_timer (cmd_clr_timer),
    .cmd_clr_wdt   (cmd_clr_wdt),
    .cmd_timer_en  (cmd_timer_en),
    .irq_n         (irq_n),
    .irq_oe        (irq_oe),
    .wdt_mode      (wdt_mode),
    .sys_on        (sys_on),
    .div_run       (div_run),
    .div_cnt       (div_cnt),
    .wdt_flag      (wdt_flag)
);

// File: tb/sim_timebase_wdt.sv
module sim_timebase_wdt;
    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG_CYCLES = 190000;

    localparam int C_SYS_EN = 0, C_SYS_DIS = 1, C_TMR_EN = 2, C_TMR_DIS = 3;
    localparam int C_WDT_EN = 4, C_WDT_DIS = 5, C_CLR_TMR = 6, C_CLR_WDT = 7;
    localparam int C_IRQ_EN = 8, C_IRQ_DIS = 9, C_FREQ = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        sys_tick = 1'b0;
    logic        src_256k = 1'b0;
    logic [10:0] cmdv = '0;
    logic [2:0]  freq_sel = 3'd7;
    logic        irq_n, irq_oe;

    int checks = 0;
    int failures = 0;
    int cycles = 0;
    bit done = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    timebase_wdt u0 (
        .clk(clk), .rst_n(rst_n), .sys_tick(sys_tick), .src_256k(src_256k),
        .cmd_sys_en(cmdv[C_SYS_EN]), .cmd_sys_dis(cmdv[C_SYS_DIS]),
        .cmd_timer_en(cmdv[C_TMR_EN]), .cmd_timer_dis(cmdv[C_TMR_DIS]),
        .cmd_wdt_en(cmdv[C_WDT_EN]), .cmd_wdt_dis(cmdv[C_WDT_DIS]),
        .cmd_clr_timer(cmdv[C_CLR_TMR]), .cmd_clr_wdt(cmdv[C_CLR_WDT]),
        .cmd_irq_en(cmdv[C_IRQ_EN]), .cmd_irq_dis(cmdv[C_IRQ_DIS]),
        .cmd_freq_ld(cmdv[C_FREQ]), .freq_sel(freq_sel),
        .irq_n(irq_n), .irq_oe(irq_oe)
    );

    // Behavioural reference model
    int m_pre, m_cnt, m_wc, m_freq;
    bit m_flag, m_sys, m_run, m_wdt, m_irqen;

    function automatic int period_of(int code);
        return 1 << (15 - code);
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            m_pre = 0; m_cnt = 0; m_wc = 0; m_flag = 0;
            m_sys = 0; m_run = 1; m_wdt = 0; m_irqen = 0; m_freq = 7;
        end else begin
            bit t32, clr, wrapped;
            int per;
            per = period_of(m_freq);
            clr = cmdv[C_CLR_TMR] || cmdv[C_CLR_WDT];
            t32 = sys_tick && m_sys && (!src_256k || m_pre == 7);
            wrapped = t32 && m_run && ((m_cnt % per) == per - 1);
            if (clr) m_pre = 0;
            else if (sys_tick && m_sys && src_256k) m_pre = (m_pre + 1) % 8;
            if (clr) m_cnt = 0;
            else if (t32 && m_run) m_cnt = (m_cnt + 1) % 32768;
            if (cmdv[C_CLR_WDT]) begin
                m_wc = 0; m_flag = 0;
            end else begin
                if (cmdv[C_IRQ_DIS]) m_flag = 0;
                if (wrapped && m_wdt) begin
                    if (m_wc == 3) m_flag = 1;
                    m_wc = (m_wc + 1) % 4;
                end
            end
            if (cmdv[C_SYS_EN]) m_sys = 1;
            if (cmdv[C_SYS_DIS]) m_sys = 0;
            if (cmdv[C_TMR_EN]) begin m_run = 1; m_wdt = 0; end
            if (cmdv[C_WDT_EN]) begin m_run = 1; m_wdt = 1; end
            if (cmdv[C_TMR_DIS] || cmdv[C_WDT_DIS]) m_run = 0;
            if (cmdv[C_IRQ_EN]) m_irqen = 1;
            if (cmdv[C_IRQ_DIS]) m_irqen = 0;
            if (cmdv[C_FREQ]) m_freq = int'(freq_sel);
        end
    end

    function automatic bit model_irq_n();
        int per;
        per = period_of(m_freq);
        if (!m_irqen) return 1'b1;
        if (m_wdt) return !m_flag;
        return !((m_cnt % per) >= per / 2);
    endfunction

    // Cycle-by-cycle comparison against the model (R6 in time-base mode, R7 in watchdog mode)
    always @(negedge clk) begin
        if (rst_n && !done) begin
            checks++;
            if (irq_oe !== m_irqen || irq_n !== model_irq_n()) begin
                failures++;
                $display("FAIL %s model compare: got oe=%b n=%b expected oe=%b n=%b",
                         m_wdt ? "R7" : "R6", irq_oe, irq_n, m_irqen, model_irq_n());
            end
        end
    end

    always @(posedge clk) begin
        cycles++;
        if (cycles > WATCHDOG_CYCLES && !done) begin
            done = 1;
            failures++;
            $display("FAIL watchdog: run did not end, got %0d cycles expected under %0d",
                     cycles, WATCHDOG_CYCLES);
            $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    task automatic expect_pin(input string req, input logic e_oe, input logic e_n);
        checks++;
        if (irq_oe !== e_oe || irq_n !== e_n) begin
            failures++;
            $display("FAIL %s: got oe=%b n=%b expected oe=%b n=%b", req, irq_oe, irq_n, e_oe, e_n);
        end
    endtask

    task automatic run_ticks(input int n);
        for (int i = 0; i < n; i++) begin
            sys_tick = 1'b1;
            @(negedge clk);
        end
        sys_tick = 1'b0;
    endtask

    task automatic do_cmd(input int pos);
        cmdv = '0;
        cmdv[pos] = 1'b1;
        @(negedge clk);
        cmdv = '0;
    endtask

    task automatic load_freq(input logic [2:0] code);
        freq_sel = code;
        do_cmd(C_FREQ);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: released pin after reset
        expect_pin("R1", 1'b0, 1'b1);
        do_cmd(C_IRQ_EN);
        expect_pin("R1", 1'b1, 1'b1);
        // R2: system off, ticks do nothing
        run_ticks(300);
        expect_pin("R2", 1'b1, 1'b1);
        do_cmd(C_SYS_EN);
        // R3: default 128 Hz from crystal
        run_ticks(127);
        expect_pin("R3", 1'b1, 1'b1);
        run_ticks(1);
        expect_pin("R3", 1'b1, 1'b0);
        // R6: square wave returns high after full period
        run_ticks(128);
        expect_pin("R6", 1'b1, 1'b1);

        // R11: stop holds count, enable resumes
        do_cmd(C_CLR_TMR);
        run_ticks(100);
        do_cmd(C_TMR_DIS);
        run_ticks(200);
        expect_pin("R11", 1'b1, 1'b1);
        do_cmd(C_TMR_EN);
        run_ticks(27);
        expect_pin("R11", 1'b1, 1'b1);
        run_ticks(1);
        expect_pin("R11", 1'b1, 1'b0);

        // R12: only cycles with sys_tick count
        do_cmd(C_CLR_TMR);
        for (int i = 0; i < 254; i++) begin
            sys_tick = (i % 2 == 0);
            @(negedge clk);
        end
        sys_tick = 1'b0;
        expect_pin("R12", 1'b1, 1'b1);
        run_ticks(1);
        expect_pin("R12", 1'b1, 1'b0);

        // R5: other frequency codes
        load_freq(3'd3);
        do_cmd(C_CLR_TMR);
        run_ticks(2047);
        expect_pin("R5", 1'b1, 1'b1);
        run_ticks(1);
        expect_pin("R5", 1'b1, 1'b0);
        load_freq(3'd0);
        do_cmd(C_CLR_TMR);
        run_ticks(16383);
        expect_pin("R5", 1'b1, 1'b1);
        run_ticks(1);
        expect_pin("R5", 1'b1, 1'b0);

        // R4: fast source prescaled by 8
        load_freq(3'd7);
        src_256k = 1'b1;
        do_cmd(C_CLR_TMR);
        run_ticks(1023);
        expect_pin("R4", 1'b1, 1'b1);
        run_ticks(1);
        expect_pin("R4", 1'b1, 1'b0);
        src_256k = 1'b0;

        // R7: timeout after four periods, latched
        do_cmd(C_CLR_WDT);
        do_cmd(C_WDT_EN);
        run_ticks(1023);
        expect_pin("R7", 1'b1, 1'b1);
        run_ticks(1);
        expect_pin("R7", 1'b1, 1'b0);
        run_ticks(600);
        expect_pin("R7", 1'b1, 1'b0);

        // R8: clear watchdog restarts the full timeout
        do_cmd(C_CLR_WDT);
        expect_pin("R8", 1'b1, 1'b1);
        run_ticks(1023);
        expect_pin("R8", 1'b1, 1'b1);
        run_ticks(1);
        expect_pin("R8", 1'b1, 1'b0);

        // R10: clear timer keeps watchdog stage count
        do_cmd(C_CLR_WDT);
        run_ticks(868);
        expect_pin("R10", 1'b1, 1'b1);
        do_cmd(C_CLR_TMR);
        run_ticks(255);
        expect_pin("R10", 1'b1, 1'b1);
        run_ticks(1);
        expect_pin("R10", 1'b1, 1'b0);

        // R9: release drops the flag
        do_cmd(C_IRQ_DIS);
        expect_pin("R9", 1'b0, 1'b1);
        do_cmd(C_IRQ_EN);
        expect_pin("R9", 1'b1, 1'b1);

        // R2: system off in watchdog mode, no timeout
        do_cmd(C_SYS_DIS);
        run_ticks(5000);
        expect_pin("R2", 1'b1, 1'b1);

        done = 1;
        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule